// File: doc/BRIEF.md
# Tagged Next-Line Fetch Predictor

This block guesses which instruction-fetch line follows the current one. It works on whole cache-line addresses and sits ahead of the instruction cache and decoder. The fetch unit can steer the next access without waiting two to three cycles for those stages.

Each cycle the block takes the current line address. It reads a tagless base table and a configurable number of tagged tables, two to four of them, all in the same cycle with no pipelining. Each tagged table keys its index and partial tag on the line address folded with a longer slice of global history than the table below it. Among the tables that hit, the one using the most history supplies the target. If no tagged table hits, the base table supplies it. When nothing is known, the prediction is simply the sequential line.

A separate update port delivers resolved outcomes. For each outcome the block adjusts confidence, replaces weak targets and allocates entries that use more history after a misprediction. It also shifts one bit into its history register.

Top module: `nlp_predictor`

## Requirements
- R1: After reset every entry is invalid and the history is all zeros. A lookup then returns `lk_line + 1` (modulo 2^16), `pred_prov` = 0 and `pred_known` = 0.
- R2: A lookup is combinational on `lk_line` and the stored state. An update is written at the clock edge that ends its cycle, so a lookup in the same cycle still sees the old state.
- R3: Tagged table t (t = 0..NUM_TAGGED-1) uses the low 4·2^t history bits. fold(h,L,w) is the XOR of bits h[i], for i < L, each placed at bit position i mod w. The index is line[4:0] ^ line[9:5] ^ fold(h,L,5), and the 8-bit tag is line[7:0] ^ line[15:8] ^ fold(h,L,8). An entry hits when it is valid and its stored tag equals the computed tag.
- R4: When one or more tagged tables hit, the highest-numbered one provides. `pred_line` is its stored target, `pred_prov` = t+1 and `pred_known` = 1.
- R5: With no tagged hit, the base entry at line[5:0] supplies a valid stored target with `pred_prov` = 0 and `pred_known` = 1. If that entry is invalid, the sequential line is used (R1 values).
- R6: Every update shifts the history left by one and inserts 1 when `upd_next` differs from `upd_line + 1`, and 0 otherwise.
- R7: On an update with a tagged provider whose target equals `upd_next`, its 2-bit confidence rises, saturating at 3, and its useful flag is set. If the target is wrong and confidence is 0, the target becomes `upd_next`; otherwise confidence falls by one.
- R8: When the overall prediction for `upd_line` (the value R4/R5 would give) differs from `upd_next`, a new entry is written into the lowest-numbered table above the provider (any table if there is no provider) whose indexed entry has a clear useful flag. The new entry is valid, takes the computed tag and `upd_next`, and starts with confidence 0 and a clear useful flag.
- R9: If R8 finds no table with a clear useful flag, the useful flag of the indexed entry in every table above the provider is cleared, and nothing is allocated.
- R10: An update with no tagged provider writes `upd_next` as a valid target into the base entry at upd_line[5:0].
- R11: While `upd_valid` is low, no table and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_line | input | 16 | Fetch-line address being looked up |
| pred_line | output | 16 | Predicted next fetch-line address |
| pred_prov | output | 2 | 0 = base/sequential, t+1 = tagged table t provided |
| pred_known | output | 1 | 1 when a tagged hit or valid base entry supplied the prediction |
| upd_valid | input | 1 | A resolved outcome is presented this cycle |
| upd_line | input | 16 | Line address whose successor was resolved |
| upd_next | input | 16 | Resolved next-line address |

## Verification
A history register that shifts in a wrong bit moves the index and tag of every tagged table. From the very next cycle, lookups that should hit report base or sequential targets with the wrong `pred_prov`. Corrupted confidence or useful state stays hidden until the same line is revisited. It then appears as a target replaced one update too early or too late, or as an allocation landing in a different table. Repeating loop patterns and dense random updates revisit the same entries within a few dozen cycles, so such faults show up quickly.

// File: rtl/nlp_pkg.sv
package nlp_pkg;

    localparam int LINE_W   = 16;
    localparam int TAG_W    = 8;
    localparam int HIST_MAX = 32;

    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        line_t            target;
        logic [1:0]       ctr;
        logic             useful;
    } tent_t;

    typedef struct packed {
        logic  valid;
        line_t target;
    } bent_t;

    function automatic int hist_len(int t);
        return 4 << t;
    endfunction

    // XOR-compress the first len history bits onto w bit positions
    function automatic logic [15:0] fold(logic [HIST_MAX-1:0] h, int len, int w);
        logic [15:0] r;
        r = '0;
        for (int i = 0; i < HIST_MAX; i++) begin
            if (i < len) begin
                r[4'(i % w)] = r[4'(i % w)] ^ h[i];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/nlp_hash.sv
module nlp_hash
    import nlp_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int HLEN   = 4,
    parameter int HIST_W = 32
) (
    input  logic [LINE_W-1:0] line,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);

    logic [HIST_MAX-1:0] h_ext;

    assign h_ext = HIST_MAX'(hist);
    assign idx   = line[IDX_W-1:0] ^ line[2*IDX_W-1:IDX_W] ^ IDX_W'(fold(h_ext, HLEN, IDX_W));
    assign tag   = line[TAG_W-1:0] ^ line[2*TAG_W-1:TAG_W] ^ TAG_W'(fold(h_ext, HLEN, TAG_W));

endmodule

// File: rtl/nlp_tag_table.sv
module nlp_tag_table
    import nlp_pkg::*;
#(
    parameter int IDX_W = 5,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] ra_idx,
    output tent_t            ra_ent,
    input  logic [IDX_W-1:0] rb_idx,
    output tent_t            rb_ent,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  tent_t            wdata
);

    tent_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < DEPTH; d++) begin
                mem[d] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign ra_ent = mem[ra_idx];
    assign rb_ent = mem[rb_idx];

endmodule

// File: rtl/nlp_base_table.sv
module nlp_base_table
    import nlp_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] ra_idx,
    output bent_t            ra_ent,
    input  logic [IDX_W-1:0] rb_idx,
    output bent_t            rb_ent,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  bent_t            wdata
);

    bent_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < DEPTH; d++) begin
                mem[d] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign ra_ent = mem[ra_idx];
    assign rb_ent = mem[rb_idx];

endmodule

// File: rtl/nlp_pick.sv
module nlp_pick #(
    parameter int N     = 3,
    parameter int SEL_W = 2
) (
    input  logic [N-1:0]     hit,
    output logic             found,
    output logic [SEL_W-1:0] sel
);

    // later (longer-history) hits override earlier ones
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                found = 1'b1;
                sel   = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/nlp_predictor.sv
module nlp_predictor
    import nlp_pkg::*;
#(
    parameter int NUM_TAGGED = 3,
    parameter int IDX_W      = 5,
    parameter int BASE_IDX_W = 6,
    parameter int HIST_W     = 32,
    localparam int PROV_W    = $clog2(NUM_TAGGED + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] lk_line,
    output logic [LINE_W-1:0] pred_line,
    output logic [PROV_W-1:0] pred_prov,
    output logic              pred_known,
    input  logic              upd_valid,
    input  logic [LINE_W-1:0] upd_line,
    input  logic [LINE_W-1:0] upd_next
);

    localparam int SEL_W = (NUM_TAGGED > 1) ? $clog2(NUM_TAGGED) : 1;

    logic [HIST_W-1:0] hist_q;

    tent_t            lk_ent [NUM_TAGGED];
    tent_t            up_ent [NUM_TAGGED];
    tent_t            wr_ent [NUM_TAGGED];
    logic [IDX_W-1:0] lk_idx [NUM_TAGGED];
    logic [IDX_W-1:0] up_idx [NUM_TAGGED];
    logic [TAG_W-1:0] lk_tag [NUM_TAGGED];
    logic [TAG_W-1:0] up_tag [NUM_TAGGED];
    logic [NUM_TAGGED-1:0] lk_hit, up_hit, wr_en;

    logic             lk_found, up_found;
    logic [SEL_W-1:0] lk_sel, up_sel;

    bent_t lk_base, up_base, base_wd;
    logic  base_we;

    // ---------------- tagged tables ----------------
    for (genvar g = 0; g < NUM_TAGGED; g++) begin : g_tab
        nlp_hash #(.IDX_W(IDX_W), .HLEN(hist_len(g)), .HIST_W(HIST_W)) u_hash_lk (
            .line(lk_line), .hist(hist_q), .idx(lk_idx[g]), .tag(lk_tag[g])
        );
        nlp_hash #(.IDX_W(IDX_W), .HLEN(hist_len(g)), .HIST_W(HIST_W)) u_hash_up (
            .line(upd_line), .hist(hist_q), .idx(up_idx[g]), .tag(up_tag[g])
        );
        nlp_tag_table #(.IDX_W(IDX_W)) u_table (
            .clk(clk), .rst(rst),
            .ra_idx(lk_idx[g]), .ra_ent(lk_ent[g]),
            .rb_idx(up_idx[g]), .rb_ent(up_ent[g]),
            .we(wr_en[g]), .widx(up_idx[g]), .wdata(wr_ent[g])
        );
        assign lk_hit[g] = lk_ent[g].valid && (lk_ent[g].tag == lk_tag[g]);
        assign up_hit[g] = up_ent[g].valid && (up_ent[g].tag == up_tag[g]);
    end

    nlp_pick #(.N(NUM_TAGGED), .SEL_W(SEL_W)) u_pick_lk (
        .hit(lk_hit), .found(lk_found), .sel(lk_sel)
    );
    nlp_pick #(.N(NUM_TAGGED), .SEL_W(SEL_W)) u_pick_up (
        .hit(up_hit), .found(up_found), .sel(up_sel)
    );

    // ---------------- base table ----------------
    nlp_base_table #(.IDX_W(BASE_IDX_W)) u_base (
        .clk(clk), .rst(rst),
        .ra_idx(lk_line[BASE_IDX_W-1:0]), .ra_ent(lk_base),
        .rb_idx(upd_line[BASE_IDX_W-1:0]), .rb_ent(up_base),
        .we(base_we), .widx(upd_line[BASE_IDX_W-1:0]), .wdata(base_wd)
    );

    // ---------------- lookup ----------------
    always_comb begin
        if (lk_found) begin
            pred_line  = lk_ent[lk_sel].target;
            pred_prov  = PROV_W'(lk_sel) + PROV_W'(1);
            pred_known = 1'b1;
        end else if (lk_base.valid) begin
            pred_line  = lk_base.target;
            pred_prov  = '0;
            pred_known = 1'b1;
        end else begin
            pred_line  = lk_line + LINE_W'(1);
            pred_prov  = '0;
            pred_known = 1'b0;
        end
    end

    // ---------------- update ----------------
    line_t            up_seq, up_pred;
    logic             mispred, alloc_any;
    logic [SEL_W-1:0] alloc_sel;

    assign up_seq = upd_line + LINE_W'(1);

    always_comb begin
        if (up_found)           up_pred = up_ent[up_sel].target;
        else if (up_base.valid) up_pred = up_base.target;
        else                    up_pred = up_seq;
    end

    assign mispred = (up_pred != upd_next);

    always_comb begin
        alloc_any = 1'b0;
        alloc_sel = '0;
        for (int t = 0; t < NUM_TAGGED; t++) begin
            if ((!up_found || t > int'(up_sel)) && !up_ent[t].useful && !alloc_any) begin
                alloc_any = 1'b1;
                alloc_sel = SEL_W'(t);
            end
        end
    end

    always_comb begin
        for (int t = 0; t < NUM_TAGGED; t++) begin
            wr_ent[t] = up_ent[t];
            wr_en[t]  = 1'b0;
            if (upd_valid) begin
                if (up_found && t == int'(up_sel)) begin
                    wr_en[t] = 1'b1;
                    if (up_ent[t].target == upd_next) begin
                        if (up_ent[t].ctr != 2'd3) wr_ent[t].ctr = up_ent[t].ctr + 2'd1;
                        wr_ent[t].useful = 1'b1;
                    end else if (up_ent[t].ctr == 2'd0) begin
                        wr_ent[t].target = upd_next;
                    end else begin
                        wr_ent[t].ctr = up_ent[t].ctr - 2'd1;
                    end
                end else if (mispred && (!up_found || t > int'(up_sel))) begin
                    if (alloc_any) begin
                        if (t == int'(alloc_sel)) begin
                            wr_en[t]  = 1'b1;
                            wr_ent[t] = '{valid: 1'b1, tag: up_tag[t], target: upd_next,
                                          ctr: 2'd0, useful: 1'b0};
                        end
                    end else begin
                        wr_en[t]         = 1'b1;
                        wr_ent[t].useful = 1'b0;
                    end
                end
            end
        end
    end

    assign base_we = upd_valid && !up_found;
    assign base_wd = '{valid: 1'b1, target: upd_next};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (upd_valid) begin
            hist_q <= {hist_q[HIST_W-2:0], (upd_next != up_seq)};
        end
    end

endmodule

// File: rtl/nlp_checker.sv
module nlp_checker
    import nlp_pkg::*;
#(
    parameter int NUM_TAGGED = 3,
    parameter int HIST_W     = 32,
    localparam int PROV_W    = $clog2(NUM_TAGGED + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [LINE_W-1:0] lk_line,
    input logic [LINE_W-1:0] pred_line,
    input logic [PROV_W-1:0] pred_prov,
    input logic              pred_known,
    input logic              upd_valid,
    input logic [LINE_W-1:0] upd_line,
    input logic [LINE_W-1:0] upd_next,
    input logic [HIST_W-1:0] hist_q
);

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q && !rst) begin
            p_hist_clear_r1: assert (hist_q == '0)
                else $error("history not cleared by reset");
        end
    end

    p_cold_seq_r1: assert property (@(posedge clk) disable iff (rst)
        !pred_known |-> (pred_line == LINE_W'(lk_line + 1'b1)) && (pred_prov == '0));

    p_prov_range_r4: assert property (@(posedge clk) disable iff (rst)
        pred_prov <= PROV_W'(NUM_TAGGED));

    p_tagged_known_r4: assert property (@(posedge clk) disable iff (rst)
        (pred_prov != '0) |-> pred_known);

    p_hist_shift_r6: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));

    p_hist_bit_r6: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> hist_q[0] == $past(upd_next != LINE_W'(upd_line + 1'b1)));

    p_hist_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(hist_q));

endmodule

bind nlp_predictor nlp_checker #(.NUM_TAGGED(NUM_TAGGED), .HIST_W(HIST_W)) u_nlp_checker (
    .clk(clk), .rst(rst), .lk_line(lk_line), .pred_line(pred_line),
    .pred_prov(pred_prov), .pred_known(pred_known), .upd_valid(upd_valid),
    .upd_line(upd_line), .upd_next(upd_next), .hist_q(hist_q)
);

// File: tb/test_nlp_predictor.sv
`timescale 1ns/1ps
module test_nlp_predictor;
    import nlp_pkg::*;

    localparam int NT = 3;
    localparam int IX = 5;
    localparam int BX = 6;
    localparam int HW = 32;
    localparam int PW = 2;
    localparam int TD = 1 << IX;
    localparam int BD = 1 << BX;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   lk_line = '0;
    logic [15:0]   pred_line;
    logic [PW-1:0] pred_prov;
    logic          pred_known;
    logic          upd_valid = 1'b0;
    logic [15:0]   upd_line = '0;
    logic [15:0]   upd_next = '0;

    nlp_predictor #(.NUM_TAGGED(NT), .IDX_W(IX), .BASE_IDX_W(BX), .HIST_W(HW)) i_nlp_predictor (
        .clk(clk), .rst(rst), .lk_line(lk_line), .pred_line(pred_line),
        .pred_prov(pred_prov), .pred_known(pred_known), .upd_valid(upd_valid),
        .upd_line(upd_line), .upd_next(upd_next)
    );

    always #10 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // ---------------- reference model state ----------------
    bit          mv   [NT][TD];
    logic [7:0]  mtag [NT][TD];
    logic [15:0] mtgt [NT][TD];
    int          mctr [NT][TD];
    bit          muse [NT][TD];
    bit          mbv  [BD];
    logic [15:0] mbt  [BD];
    logic [31:0] mh;

    function automatic int bfold(logic [31:0] h, int len, int w);
        int r = 0;
        for (int i = 0; i < len; i++) r = r ^ (int'(h[i]) << (i % w));
        return r;
    endfunction

    function automatic int bidx(int t, logic [15:0] l);
        int li = int'(l);
        return ((li ^ (li >> IX)) ^ bfold(mh, 4 << t, IX)) & (TD - 1);
    endfunction

    function automatic int btag(int t, logic [15:0] l);
        int li = int'(l);
        return ((li ^ (li >> 8)) ^ bfold(mh, 4 << t, 8)) & 255;
    endfunction

    // returns provider table or -1
    function automatic int bprov(logic [15:0] l);
        int p = -1;
        for (int t = 0; t < NT; t++) begin
            int i = bidx(t, l);
            if (mv[t][i] && int'(mtag[t][i]) == btag(t, l)) p = t;
        end
        return p;
    endfunction

    function automatic logic [15:0] bpred(logic [15:0] l, int p);
        if (p >= 0) return mtgt[p][bidx(p, l)];
        if (mbv[int'(l) % BD]) return mbt[int'(l) % BD];
        return l + 16'd1;
    endfunction

    task automatic model_reset();
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < TD; i++) begin
                mv[t][i] = 0; mtag[t][i] = '0; mtgt[t][i] = '0; mctr[t][i] = 0; muse[t][i] = 0;
            end
        for (int i = 0; i < BD; i++) begin mbv[i] = 0; mbt[i] = '0; end
        mh = '0;
    endtask

    task automatic model_update(logic [15:0] ul, logic [15:0] un);
        int p = bprov(ul);
        bit miss = (bpred(ul, p) != un);
        int idx [NT];
        int tg  [NT];
        int alloc = -1;
        for (int t = 0; t < NT; t++) begin idx[t] = bidx(t, ul); tg[t] = btag(t, ul); end
        if (p >= 0) begin
            if (mtgt[p][idx[p]] == un) begin
                if (mctr[p][idx[p]] < 3) mctr[p][idx[p]]++;
                muse[p][idx[p]] = 1;
            end else if (mctr[p][idx[p]] == 0) begin
                mtgt[p][idx[p]] = un;
            end else begin
                mctr[p][idx[p]]--;
            end
        end else begin
            mbv[int'(ul) % BD] = 1;
            mbt[int'(ul) % BD] = un;
        end
        if (miss) begin
            for (int t = p + 1; t < NT; t++)
                if (alloc < 0 && !muse[t][idx[t]]) alloc = t;
            if (alloc >= 0) begin
                mv[alloc][idx[alloc]] = 1;   mtag[alloc][idx[alloc]] = 8'(tg[alloc]);
                mtgt[alloc][idx[alloc]] = un; mctr[alloc][idx[alloc]] = 0;
                muse[alloc][idx[alloc]] = 0;
            end else begin
                for (int t = p + 1; t < NT; t++) muse[t][idx[t]] = 0;
            end
        end
        mh = {mh[30:0], (un != ul + 16'd1)};
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one cycle: drive, compare outputs against the model, then advance the model
    task automatic step(logic [15:0] lk, bit uv, logic [15:0] ul, logic [15:0] un, string req);
        int p;
        logic [15:0] e_line;
        @(negedge clk);
        lk_line = lk; upd_valid = uv; upd_line = ul; upd_next = un;
        #2;
        p = bprov(lk);
        e_line = bpred(lk, p);
        check(pred_line == e_line, req, "pred_line", int'(pred_line), int'(e_line));
        check(int'(pred_prov) == p + 1, req, "pred_prov", int'(pred_prov), p + 1);
        check(pred_known == (p >= 0 || mbv[int'(lk) % BD]), req, "pred_known",
              int'(pred_known), int'(p >= 0 || mbv[int'(lk) % BD]));
        if (uv) model_update(ul, un);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; upd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic run_loop(int trips, int iters, string req);
        logic [15:0] cur = 16'd100;
        logic [15:0] nxt;
        int cnt = 0;
        for (int k = 0; k < iters; k++) begin
            case (cur)
                16'd100: nxt = 16'd101;
                16'd101: nxt = 16'd102;
                16'd102: begin
                    cnt++;
                    if (cnt < trips) nxt = 16'd100;
                    else begin nxt = 16'd300; cnt = 0; end
                end
                16'd300: nxt = 16'd301;
                default: nxt = 16'd100;
            endcase
            step(cur, 1'b1, cur, nxt, req);
            cur = nxt;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        do_reset();

        // R1: cold lookups, including wrap of the sequential line
        step(16'h0000, 1'b0, 16'h0, 16'h0, "R1");
        step(16'hFFFF, 1'b0, 16'h0, 16'h0, "R1");
        step(16'h1234, 1'b0, 16'h0, 16'h0, "R1");

        // R2: update visible only from the next cycle; R10/R5: base learns
        step(16'd10, 1'b1, 16'd10, 16'd50, "R2");
        step(16'd10, 1'b0, 16'd77, 16'd99, "R5 R10");
        // R11: idle update inputs change nothing
        step(16'd77, 1'b0, 16'd77, 16'd5, "R11");
        step(16'd10, 1'b0, 16'd10, 16'd5, "R11");

        // R3/R4/R6/R7/R8: history-dependent loop patterns
        run_loop(3, 400, "R3 R4 R6 R7 R8 short loop");
        run_loop(6, 600, "R3 R4 R6 R7 R8 long loop");

        // R7/R8/R9: dense random traffic on a small line set
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] l  = 16'($urandom_range(0, 40));
            logic [15:0] ul = 16'($urandom_range(0, 40));
            logic [15:0] un = ($urandom_range(0, 2) == 0) ? ul + 16'd1
                                                         : 16'($urandom_range(0, 40));
            step(l, ($urandom_range(0, 3) != 0), ul, un, "R7 R8 R9 R11 random");
        end

        // R1: reset in the middle of learned state
        do_reset();
        step(16'd100, 1'b0, 16'h0, 16'h0, "R1");
        step(16'd102, 1'b0, 16'h0, 16'h0, "R1");
        step(16'd10,  1'b0, 16'h0, 16'h0, "R1");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule